// File: doc/BRIEF.md
# I2C Display Memory Slave

This block is an I2C target that gives a bus controller access to a small display store: one command register and twelve bytes of memory. It samples SCL and SDA with a fast system clock and pulls SDA low through an open-drain enable. The first byte after a write address is the command byte. It sets three display control fields and loads a four-bit memory pointer. Each later data byte is stored at the pointer, and the pointer then advances.

A read returns bytes from successive pointer locations until the controller answers with NACK. A read can follow a command phase through a repeated Start. It can also begin at once with a read address, and it then starts from the pointer value already held. The pointer runs from 0x0 to 0xB and wraps to 0x0 after 0xB. The lower six locations drive the segment pattern output. The upper six drive the blink pattern output.

Top module: `i2c_dispmem_slave`

## Requirements
- R1: The block acknowledges the 7-bit address 0x39. It takes the eighth bit as R/W, with 1 meaning read, and pulls SDA low during the acknowledge bit of the address byte.
- R2: An address that does not match gets no acknowledge. Every byte clocked after it, up to the next Start, leaves the memory, the control fields and SDA untouched.
- R3: The command byte drives three outputs: bit 7 drives `disp_off`, bits 6:5 drive `frame_sel`, and bit 4 drives `blink_sel`. Bits 3:0 load the pointer.
- R4: Each data byte of a write is acknowledged and stored at the pointer, and the pointer then increments by one.
- R5: After location 0xB the pointer wraps to 0x0, for both writes and reads.
- R6: A pointer value of 0xC to 0xF in the command byte loads 0x0.
- R7: After a command byte and a repeated Start with a read address, the block returns bytes from successive locations, starting at the commanded pointer, most significant bit first.
- R8: A read that starts directly with the read address returns data starting at the pointer left by earlier transfers. Every byte read advances the pointer by one.
- R9: When the controller answers a read byte with NACK, the block releases SDA and drives nothing more until the next Start.
- R10: Reset clears the command fields, the pointer and all twelve memory bytes to zero, and releases SDA.
- R11: Location n (0 to 5) appears on `seg_data[8n+7:8n]`, and location 6+n appears on `blink_data[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| disp_off | output | 1 | Display blanking control |
| frame_sel | output | 2 | Frame rate selection |
| blink_sel | output | 1 | Blink rate selection |
| seg_data | output | 48 | Segment pattern bytes, locations 0 to 5 |
| blink_data | output | 48 | Blink pattern bytes, locations 6 to 11 |

## Verification
The bench targets the corners of the pointer: a write that runs from 0xA across the wrap, a command that loads an out-of-range pointer, and a direct read that must continue from where a previous read stopped. A design that wrapped late would write outside the twelve bytes or drop a byte. One that passed 0xE through would leave data in a hidden place and let the outputs drift from the model. One that reset the pointer on every Start would return location 0 for the direct read. A foreign address followed by full data bytes checks that a non-matching transfer neither acknowledges nor writes. A NACK at the end of a read checks that SDA is released and no further byte is fetched.

// File: rtl/i2c_dm_pkg.sv
`timescale 1ns/1ps
package i2c_dm_pkg;
  localparam int BYTE_W      = 8;
  localparam int PTR_FIELD_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/i2c_dm_sync_det.sv
`timescale 1ns/1ps
module i2c_dm_sync_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign scl_d     = scl_p[STAGES];
  assign sda_s     = sda_p[STAGES-1];
  assign sda_d     = sda_p[STAGES];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  p_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));
endmodule

// File: rtl/i2c_dm_regfile.sv
`timescale 1ns/1ps
module i2c_dm_regfile
  import i2c_dm_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cmd_we,
  input  logic [BYTE_W-1:0]             cmd_data,
  input  logic                          wr_we,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic                          rd_adv,
  output logic [BYTE_W-1:0]             rd_data,
  output logic                          disp_off,
  output logic [1:0]                    frame_sel,
  output logic                          blink_sel,
  output logic [(DEPTH/2)*BYTE_W-1:0]   seg_data,
  output logic [(DEPTH/2)*BYTE_W-1:0]   blink_data
);
  localparam int HALF  = DEPTH / 2;
  localparam int PTR_W = PTR_FIELD_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptr_next;
  logic [PTR_W-1:0]  cmd_ptr;

  assign ptr_next = (ptr == LAST) ? '0 : ptr + PTR_W'(1);
  assign cmd_ptr  = (cmd_data[PTR_W-1:0] > LAST) ? '0 : cmd_data[PTR_W-1:0];
  assign rd_data  = mem[ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      disp_off  <= 1'b0;
      frame_sel <= 2'b00;
      blink_sel <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (cmd_we) begin
        disp_off  <= cmd_data[7];
        frame_sel <= cmd_data[6:5];
        blink_sel <= cmd_data[4];
        ptr       <= cmd_ptr;
      end else if (wr_we) begin
        mem[ptr] <= wr_data;
        ptr      <= ptr_next;
      end else if (rd_adv) begin
        ptr <= ptr_next;
      end
    end
  end

  for (genvar g = 0; g < HALF; g++) begin : g_out
    assign seg_data[g*BYTE_W +: BYTE_W]   = mem[g];
    assign blink_data[g*BYTE_W +: BYTE_W] = mem[g+HALF];
  end

  p_ptr_range_r6: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!cmd_we && (wr_we || rd_adv) && ptr == LAST) |=> ptr == '0);
  p_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (!cmd_we && (wr_we || rd_adv) && ptr != LAST) |=> ptr == $past(ptr) + PTR_W'(1));
  p_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> (disp_off == $past(cmd_data[7]) && blink_sel == $past(cmd_data[4])));
endmodule

// File: rtl/i2c_dm_bus_fsm.sv
`timescale 1ns/1ps
module i2c_dm_bus_fsm
  import i2c_dm_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              cmd_we,
  output logic              wr_we,
  output logic              rd_adv,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  bus_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic              byte_done;
  logic              rd_mode;
  logic              rack_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      byte_done <= 1'b0;
      rd_mode   <= 1'b0;
      rack_ok   <= 1'b0;
      sda_oe    <= 1'b0;
      cmd_we    <= 1'b0;
      wr_we     <= 1'b0;
      rd_adv    <= 1'b0;
      byte_out  <= '0;
    end else begin
      cmd_we <= 1'b0;
      wr_we  <= 1'b0;
      rd_adv <= 1'b0;
      if (start_det) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
              if (cnt == CNT_LAST) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              cnt       <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_CMD) begin
                sda_oe   <= 1'b1;
                cmd_we   <= 1'b1;
                byte_out <= shreg;
                state    <= ST_CMD_ACK;
              end else begin
                sda_oe   <= 1'b1;
                wr_we    <= 1'b1;
                byte_out <= shreg;
                state    <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_mode) begin
                tx     <= rd_data;
                rd_adv <= 1'b1;
                sda_oe <= ~rd_data[BYTE_W-1];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
                cnt    <= cnt + CNT_W'(1);
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              rack_ok <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (rack_ok) begin
                tx     <= rd_data;
                rd_adv <= 1'b1;
                sda_oe <= ~rd_data[BYTE_W-1];
                state  <= ST_RD;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> state == ST_ADDR);
  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_SKIP |-> !sda_oe && !cmd_we && !wr_we && !rd_adv);
  p_nack_release_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD_ACK && scl_fall && !rack_ok && !start_det && !stop_det) |=> !sda_oe);
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  p_one_op_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({cmd_we, wr_we, rd_adv}) <= 1);
endmodule

// File: rtl/i2c_dispmem_slave.sv
`timescale 1ns/1ps
module i2c_dispmem_slave
  import i2c_dm_pkg::*;
#(
  parameter int         DEPTH       = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h39
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe,
  output logic                        disp_off,
  output logic [1:0]                  frame_sel,
  output logic                        blink_sel,
  output logic [(DEPTH/2)*BYTE_W-1:0] seg_data,
  output logic [(DEPTH/2)*BYTE_W-1:0] blink_data
);
  logic scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic cmd_we, wr_we, rd_adv;
  logic [BYTE_W-1:0] byte_out, rd_data;

  i2c_dm_sync_det #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_dm_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe), .cmd_we(cmd_we), .wr_we(wr_we),
    .rd_adv(rd_adv), .byte_out(byte_out)
  );

  i2c_dm_regfile #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(byte_out),
    .wr_we(wr_we), .wr_data(byte_out), .rd_adv(rd_adv), .rd_data(rd_data),
    .disp_off(disp_off), .frame_sel(frame_sel), .blink_sel(blink_sel),
    .seg_data(seg_data), .blink_data(blink_data)
  );
endmodule

// File: tb/i2c_dispmem_slave_tb.sv
`timescale 1ns/1ps
module i2c_dispmem_slave_tb;
  localparam int QT = 32;   // quarter SCL period, 8 clocks
  localparam logic [7:0] AW = 8'h72, AR = 8'h73;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, disp_off, blink_sel;
  logic [1:0] frame_sel;
  logic [47:0] seg_data, blink_data;
  wire sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;
  string cmp_tag = "R10";

  // behavioural reference state
  logic [7:0] exp_mem [12];
  int exp_ptr = 0;
  logic [7:0] exp_cmd = 8'h00;

  always #2 clk = ~clk;

  i2c_dispmem_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .disp_off(disp_off), .frame_sel(frame_sel), .blink_sel(blink_sel),
    .seg_data(seg_data), .blink_data(blink_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] pack(input int base);
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = exp_mem[base+i];
    return v;
  endfunction

  // per-clock comparison against the model while the bus is quiet (R11, R3)
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(seg_data == pack(0), {cmp_tag, "/R11 seg"}, seg_data, pack(0));
      chk(blink_data == pack(6), {cmp_tag, "/R11 blink"}, blink_data, pack(6));
      chk({disp_off, frame_sel, blink_sel} == exp_cmd[7:4], {cmp_tag, "/R3 ctrl"},
          {disp_off, frame_sel, blink_sel}, exp_cmd[7:4]);
      chk(sda_oe == 1'b0, {cmp_tag, "/R9 idle sda"}, sda_oe, 0);
    end
  end

  task automatic quiet(input string tag);
    cmp_tag = tag;
    repeat (10) @(negedge clk);
    cmp_en = 1;
    repeat (20) @(negedge clk);
    cmp_en = 0;
  endtask

  task automatic bus_start();
    sda_m = 1; #QT; scl_m = 1; #QT; sda_m = 0; #QT; scl_m = 0; #QT;
  endtask

  task automatic bus_stop();
    sda_m = 0; #QT; scl_m = 1; #QT; sda_m = 1; #QT;
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #QT; scl_m = 1; #(2*QT); scl_m = 0; #QT;
    end
    sda_m = 1; #QT; scl_m = 1; #QT;
    acked = ~sda_bus;
    #QT; scl_m = 0; #QT;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      #QT; scl_m = 1; #QT; b[i] = sda_bus; #QT; scl_m = 0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; #QT; scl_m = 1; #(2*QT); scl_m = 0; #QT;
    sda_m = 1;
  endtask

  function automatic int nxt(input int p);
    return (p == 11) ? 0 : p + 1;
  endfunction

  task automatic model_cmd(input logic [7:0] c);
    exp_cmd = c;
    exp_ptr = (c[3:0] > 4'hB) ? 0 : int'(c[3:0]);
  endtask

  task automatic do_write(input logic [7:0] c, input logic [7:0] data[$], input string tag);
    bit a;
    bus_start();
    wr_byte(AW, a); chk(a, "R1 write address ack", a, 1);
    wr_byte(c, a);  chk(a, {tag, " command ack"}, a, 1);
    model_cmd(c);
    foreach (data[i]) begin
      wr_byte(data[i], a);
      chk(a, "R4 data ack", a, 1);
      exp_mem[exp_ptr] = data[i];
      exp_ptr = nxt(exp_ptr);
    end
    bus_stop();
  endtask

  task automatic read_seq(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n-1, b);
      chk(b == exp_mem[exp_ptr], tag, b, exp_mem[exp_ptr]);
      exp_ptr = nxt(exp_ptr);
    end
    #QT;
    chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit a;
    logic [7:0] q[$];
    for (int i = 0; i < 12; i++) exp_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    // R10: reset state
    quiet("R10");

    // R3/R4: command 0xB2 then five bytes from location 2
    q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    do_write(8'hB2, q, "R3");
    quiet("R4");

    // R5: write across the wrap from 0xA
    q = '{8'hA1, 8'hB1, 8'hC1};
    do_write(8'h0A, q, "R5");
    quiet("R5");

    // R6: out-of-range pointer loads 0
    q = '{8'h5A};
    do_write(8'h0E, q, "R6");
    quiet("R6");

    // R2: foreign address, bytes after it ignored
    bus_start();
    wr_byte(8'h50, a); chk(!a, "R2 foreign address not acked", a, 0);
    wr_byte(8'h8F, a); chk(!a, "R2 byte after foreign address", a, 0);
    wr_byte(8'hFF, a); chk(!a, "R2 second byte after foreign address", a, 0);
    bus_stop();
    quiet("R2");

    // R7: command phase then repeated start and read of three bytes
    bus_start();
    wr_byte(AW, a); chk(a, "R1 address ack", a, 1);
    wr_byte(8'h03, a); chk(a, "R7 command ack", a, 1);
    model_cmd(8'h03);
    bus_start();
    wr_byte(AR, a); chk(a, "R1 read address ack", a, 1);
    read_seq(3, "R7 read data");
    bus_stop();
    quiet("R7");

    // R8: direct read continues from held pointer (6)
    bus_start();
    wr_byte(AR, a); chk(a, "R8 read address ack", a, 1);
    read_seq(2, "R8 read data");
    bus_stop();
    quiet("R8");

    // R5: read across the wrap
    bus_start();
    wr_byte(AW, a);
    wr_byte(8'h1B, a); chk(a, "R5 command ack", a, 1);
    model_cmd(8'h1B);
    bus_start();
    wr_byte(AR, a);
    read_seq(3, "R5 read wrap");
    bus_stop();
    quiet("R5 read");

    // R10: reset again clears everything
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
    for (int i = 0; i < 12; i++) exp_mem[i] = 8'h00;
    exp_cmd = 8'h00; exp_ptr = 0;
    quiet("R10 again");
    // R10: pointer back at 0 after reset
    bus_start();
    wr_byte(AR, a);
    read_seq(1, "R10 pointer cleared");
    bus_stop();
    quiet("R10 end");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule